// File: doc/BRIEF.md
# Per-Destination Virtual Output Queues

This block is the ingress queueing stage of a slotted switch. Once the forwarding lookup has chosen a destination, the block receives a buffer descriptor and a queue number. The descriptor says where the packet sits in packet memory; the packet data itself never passes through the block. There is one descriptor queue for each egress slot, one for multicast traffic and one raw queue for packets bound to the local processor. All of these queues share a single descriptor store and are kept as linked lists.

Every queue that holds at least one descriptor, and whose backpressure input is low, raises a request toward the fabric scheduler. The arbitration itself is outside this block. When a grant names a queue, the block removes that queue's head descriptor and presents it on the next cycle. Each queue has its own backpressure input, so a congested egress slot stalls only its own queue. Descriptors for that slot keep collecting while traffic to every other slot flows on.

Each queue reports its element count. The raw queue's count is how processor overload shows up. Each queue also takes a length limit: an arrival that finds its queue at the limit is refused and counted in that queue's drop counter.

Top module: `voq_core`

## Requirements
- R1: Queue numbers 0 to NUM_SLOTS-1 address the unicast slot queues, NUM_SLOTS the multicast queue and NUM_SLOTS+1 the local raw queue (16, 17 at default). An accepted enqueue appends the descriptor to the addressed queue, and descriptors leave each queue in arrival order.
- R2: Slice q of `depth_o`, bits [q*CNT_W +: CNT_W], gives the element count of queue q, updated in the cycle after the enqueue or dequeue that changes it.
- R3: A grant for a queue that is non-empty and not backpressured sets `deq_valid_o` in the next cycle, with that queue's head descriptor on `deq_desc_o`, and lowers the queue's count by one.
- R4: `req_o[q]` is high exactly when queue q is non-empty and `bp_i[q]` is low. It follows `bp_i` in the same cycle.
- R5: An enqueue is refused when its queue's count is already at or above the limit in slice q of `limit_i`, or when its queue number is above NUM_SLOTS+1. A refusal pulses `enq_drop_o` in the next cycle and leaves the queue unchanged. For a valid queue number it also increments slice q of `drop_cnt_o`, which wraps modulo 2^DROP_W. A limit of zero refuses every arrival.
- R6: While `bp_i[q]` is high, enqueues to queue q still accumulate, and the other queues accept and deliver as usual.
- R7: All queues together hold at most DEPTH descriptors. An enqueue that arrives while all DEPTH entries are in use is refused as in R5, even if a dequeue happens in the same cycle. An entry freed by a dequeue can be reused from the next cycle.
- R8: A grant to an empty queue, to a backpressured queue, or with a queue number above NUM_SLOTS+1 dequeues nothing. It pulses `gnt_err_o` in the next cycle and leaves `deq_valid_o` low.
- R9: An enqueue and a grant to the same queue in the same cycle are both served, including when the queue holds one descriptor. The count is then unchanged and the order is preserved.
- R10: During and just after reset all counts and drop counters are zero, and `req_o`, `deq_valid_o`, `gnt_err_o` and `enq_drop_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid_i | input | 1 | Descriptor offered this cycle |
| enq_qid_i | input | QID_W | Target queue of the offered descriptor |
| enq_desc_i | input | DESC_W | Buffer descriptor |
| limit_i | input | NQ*CNT_W | Per-queue length limits, CNT_W bits per queue |
| bp_i | input | NQ | Per-queue backpressure |
| req_o | output | NQ | Per-queue request to the scheduler |
| gnt_valid_i | input | 1 | Grant present this cycle |
| gnt_qid_i | input | QID_W | Queue named by the grant |
| deq_valid_o | output | 1 | Dequeued descriptor valid (one cycle after grant) |
| deq_desc_o | output | DESC_W | Dequeued descriptor |
| gnt_err_o | output | 1 | Previous cycle's grant was rejected |
| enq_drop_o | output | 1 | Previous cycle's enqueue was refused |
| depth_o | output | NQ*CNT_W | Per-queue element counts |
| drop_cnt_o | output | NQ*DROP_W | Per-queue refusal counters |

## Verification
The assertions assume that every input is driven to a known value from reset onward. They also assume at most one enqueue and one grant per cycle, since the port carries only one of each. Nothing is assumed about whether a grant is legal, because rejecting bad grants is itself checked behaviour. The stimulus changes inputs only between clock edges. It sends grants to empty queues, to backpressured queues and to out-of-range numbers, and arrivals beyond both the per-queue limit and the shared store. The conservation check between stored counts and free entries therefore has to hold under every refusal path.

// File: rtl/voq_pkg.sv
package voq_pkg;

    // Outcome of the grant presented in one cycle
    typedef enum logic [1:0] {
        GNT_IDLE   = 2'd0,
        GNT_TAKE   = 2'd1,
        GNT_REJECT = 2'd2
    } gnt_kind_e;

    // Unicast slots plus the multicast queue and the local raw queue
    function automatic int queue_total(input int slots);
        return slots + 2;
    endfunction

endpackage

// File: rtl/voq_free_pool.sv
module voq_free_pool #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en_i,
    input  logic             free_en_i,
    input  logic [AW-1:0]    free_idx_i,
    output logic [AW-1:0]    alloc_idx_o,
    output logic [DEPTH-1:0] free_map_o
);

    logic [DEPTH-1:0] free_d, free_q;

    // lowest free entry
    always_comb begin
        alloc_idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_q[i]) alloc_idx_o = AW'(i);
        end
    end

    always_comb begin
        free_d = free_q;
        if (alloc_en_i) free_d[alloc_idx_o] = 1'b0;
        if (free_en_i)  free_d[free_idx_i]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= free_d;
    end

    assign free_map_o = free_q;

endmodule

// File: rtl/voq_link_ram.sv
module voq_link_ram #(
    parameter int DEPTH  = 64,
    parameter int DESC_W = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_idx_i,
    input  logic [DESC_W-1:0] wr_desc_i,
    input  logic              lk_en_i,
    input  logic [AW-1:0]     lk_idx_i,
    input  logic [AW-1:0]     lk_val_i,
    input  logic [AW-1:0]     rd_idx_i,
    output logic [DESC_W-1:0] rd_desc_o,
    output logic [AW-1:0]     rd_next_o
);

    logic [DESC_W-1:0] desc_mem [DEPTH];
    logic [AW-1:0]     nxt_mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) desc_mem[wr_idx_i] <= wr_desc_i;
        if (lk_en_i) nxt_mem[lk_idx_i]  <= lk_val_i;
    end

    assign rd_desc_o = desc_mem[rd_idx_i];
    assign rd_next_o = nxt_mem[rd_idx_i];

endmodule

// File: rtl/voq_core.sv
module voq_core
    import voq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int DEPTH     = 64,
    parameter int DESC_W    = 16,
    parameter int DROP_W    = 8,
    localparam int NQ    = queue_total(NUM_SLOTS),
    localparam int QID_W = $clog2(NQ),
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enq_valid_i,
    input  logic [QID_W-1:0]    enq_qid_i,
    input  logic [DESC_W-1:0]   enq_desc_i,
    input  logic [NQ*CNT_W-1:0] limit_i,
    input  logic [NQ-1:0]       bp_i,
    output logic [NQ-1:0]       req_o,
    input  logic                gnt_valid_i,
    input  logic [QID_W-1:0]    gnt_qid_i,
    output logic                deq_valid_o,
    output logic [DESC_W-1:0]   deq_desc_o,
    output logic                gnt_err_o,
    output logic                enq_drop_o,
    output logic [NQ*CNT_W-1:0] depth_o,
    output logic [NQ*DROP_W-1:0] drop_cnt_o
);

    typedef struct packed {
        logic [NQ-1:0][AW-1:0]     head;
        logic [NQ-1:0][AW-1:0]     tail;
        logic [NQ-1:0][CNT_W-1:0]  cnt;
        logic [NQ-1:0][DROP_W-1:0] drops;
        logic                      deq_valid;
        logic [DESC_W-1:0]         deq_desc;
        logic                      gnt_err;
        logic                      enq_drop;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0]  free_map;
    logic [AW-1:0]     alloc_idx;
    logic              alloc_ok;
    logic [DESC_W-1:0] rd_desc;
    logic [AW-1:0]     rd_next;
    logic [AW-1:0]     rd_idx;

    logic              enq_id_ok, gnt_id_ok;
    logic [QID_W-1:0]  eq, gq;
    logic [CNT_W-1:0]  enq_limit;
    logic              enq_room, do_enq, enq_refuse, do_deq;
    logic              lk_en;
    logic [AW-1:0]     lk_idx;
    gnt_kind_e         gnt_kind;

    assign alloc_ok  = |free_map;
    assign enq_id_ok = int'(enq_qid_i) < NQ;
    assign gnt_id_ok = int'(gnt_qid_i) < NQ;
    assign eq        = enq_id_ok ? enq_qid_i : '0;
    assign gq        = gnt_id_ok ? gnt_qid_i : '0;
    assign enq_limit = limit_i[int'(eq)*CNT_W +: CNT_W];
    assign rd_idx    = s_q.head[gq];

    // grant classification
    always_comb begin
        if (!gnt_valid_i)
            gnt_kind = GNT_IDLE;
        else if (!gnt_id_ok || s_q.cnt[gq] == '0 || bp_i[gq])
            gnt_kind = GNT_REJECT;
        else
            gnt_kind = GNT_TAKE;
    end

    assign do_deq     = (gnt_kind == GNT_TAKE);
    assign enq_room   = enq_id_ok && (s_q.cnt[eq] < enq_limit) && alloc_ok;
    assign do_enq     = enq_valid_i && enq_room;
    assign enq_refuse = enq_valid_i && !enq_room;

    // next-state
    always_comb begin
        s_d           = s_q;
        lk_en         = 1'b0;
        lk_idx        = s_q.tail[eq];
        s_d.deq_valid = do_deq;
        s_d.gnt_err   = (gnt_kind == GNT_REJECT);
        s_d.enq_drop  = enq_refuse;

        if (do_deq) begin
            s_d.deq_desc = rd_desc;
            s_d.head[gq] = rd_next;
            s_d.cnt[gq]  = s_q.cnt[gq] - CNT_W'(1);
        end

        if (do_enq) begin
            if (s_d.cnt[eq] == '0) begin
                s_d.head[eq] = alloc_idx;
            end else begin
                lk_en = 1'b1;
            end
            s_d.tail[eq] = alloc_idx;
            s_d.cnt[eq]  = s_d.cnt[eq] + CNT_W'(1);
        end

        if (enq_refuse && enq_id_ok) begin
            s_d.drops[eq] = s_q.drops[eq] + DROP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    voq_free_pool #(
        .DEPTH (DEPTH)
    ) i_pool (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en_i  (do_enq),
        .free_en_i   (do_deq),
        .free_idx_i  (rd_idx),
        .alloc_idx_o (alloc_idx),
        .free_map_o  (free_map)
    );

    voq_link_ram #(
        .DEPTH  (DEPTH),
        .DESC_W (DESC_W)
    ) i_ram (
        .clk       (clk),
        .wr_en_i   (do_enq),
        .wr_idx_i  (alloc_idx),
        .wr_desc_i (enq_desc_i),
        .lk_en_i   (lk_en),
        .lk_idx_i  (lk_idx),
        .lk_val_i  (alloc_idx),
        .rd_idx_i  (rd_idx),
        .rd_desc_o (rd_desc),
        .rd_next_o (rd_next)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_out
        assign req_o[q] = (s_q.cnt[q] != '0) && !bp_i[q];
        assign depth_o[q*CNT_W +: CNT_W]     = s_q.cnt[q];
        assign drop_cnt_o[q*DROP_W +: DROP_W] = s_q.drops[q];
    end

    assign deq_valid_o = s_q.deq_valid;
    assign deq_desc_o  = s_q.deq_desc;
    assign gnt_err_o   = s_q.gnt_err;
    assign enq_drop_o  = s_q.enq_drop;

endmodule

// File: rtl/voq_core_chk.sv
module voq_core_chk #(
    parameter int NQ     = 18,
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 7,
    parameter int DROP_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enq_valid_i,
    input logic                 gnt_valid_i,
    input logic [NQ-1:0]        bp_i,
    input logic                 deq_valid_o,
    input logic                 gnt_err_o,
    input logic [NQ*CNT_W-1:0]  depth_o,
    input logic [NQ*DROP_W-1:0] drop_cnt_o,
    input logic [DEPTH-1:0]     pool_map
);

    int stored_plus_free;

    always_comb begin
        stored_plus_free = $countones(pool_map);
        for (int q = 0; q < NQ; q++) begin
            stored_plus_free += int'(depth_o[q*CNT_W +: CNT_W]);
        end
    end

    // R7
    storage_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stored_plus_free == DEPTH);

    // R3
    deq_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid_o |-> $past(gnt_valid_i));

    // R8
    err_or_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({deq_valid_o, gnt_err_o}));

    // R5
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enq_valid_i |=> $stable(drop_cnt_o));

    for (genvar q = 0; q < NQ; q++) begin : g_bp
        // R6
        bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bp_i[q] |=> depth_o[q*CNT_W +: CNT_W] >= $past(depth_o[q*CNT_W +: CNT_W]));
    end

endmodule

bind voq_core voq_core_chk #(
    .NQ     (NQ),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .DROP_W (DROP_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_valid_i (enq_valid_i),
    .gnt_valid_i (gnt_valid_i),
    .bp_i        (bp_i),
    .deq_valid_o (deq_valid_o),
    .gnt_err_o   (gnt_err_o),
    .depth_o     (depth_o),
    .drop_cnt_o  (drop_cnt_o),
    .pool_map    (free_map)
);

// File: tb/test_voq_core.sv
module test_voq_core;

    localparam int NS     = 16;
    localparam int NQ     = NS + 2;
    localparam int DEPTH  = 64;
    localparam int DESC_W = 16;
    localparam int DROP_W = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int QID_W  = $clog2(NQ);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 1'b0;
    logic [QID_W-1:0] enq_qid = '0;
    logic [DESC_W-1:0] enq_desc = '0;
    logic [NQ*CNT_W-1:0] limit = '0;
    logic [NQ-1:0] bp = '0;
    logic gnt_valid = 1'b0;
    logic [QID_W-1:0] gnt_qid = '0;
    logic [NQ-1:0] req;
    logic deq_valid, gnt_err, enq_drop;
    logic [DESC_W-1:0] deq_desc;
    logic [NQ*CNT_W-1:0] depth;
    logic [NQ*DROP_W-1:0] drops;

    always #2 clk = ~clk;

    voq_core #(.NUM_SLOTS(NS), .DEPTH(DEPTH), .DESC_W(DESC_W), .DROP_W(DROP_W)) i_voq_core (
        .clk(clk), .rst_n(rst_n),
        .enq_valid_i(enq_valid), .enq_qid_i(enq_qid), .enq_desc_i(enq_desc),
        .limit_i(limit), .bp_i(bp), .req_o(req),
        .gnt_valid_i(gnt_valid), .gnt_qid_i(gnt_qid),
        .deq_valid_o(deq_valid), .deq_desc_o(deq_desc), .gnt_err_o(gnt_err),
        .enq_drop_o(enq_drop), .depth_o(depth), .drop_cnt_o(drops)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int tag = 1;

    // reference model
    int mq [NQ][$];
    int mdrop [NQ];
    bit exp_dv, exp_err, exp_edrop;
    int exp_desc;

    task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req_tag, act, exp, $time);
        end
    endtask

    function automatic int total_stored();
        int t = 0;
        for (int q = 0; q < NQ; q++) t += mq[q].size();
        return t;
    endfunction

    function automatic int lim_of(input int q);
        return int'(limit[q*CNT_W +: CNT_W]);
    endfunction

    task automatic model_update();
        int tot = total_stored();
        bit eok = int'(enq_qid) < NQ;
        bit gok = int'(gnt_qid) < NQ;
        bit take = 1'b0;
        bit room;
        exp_err = 1'b0;
        if (gnt_valid) begin
            if (gok && mq[gnt_qid].size() > 0 && !bp[gnt_qid]) take = 1'b1;
            else exp_err = 1'b1;
        end
        room = eok && (mq[eok ? int'(enq_qid) : 0].size() < lim_of(eok ? int'(enq_qid) : 0))
               && (tot < DEPTH);
        exp_dv = take;
        if (take) exp_desc = mq[gnt_qid].pop_front();
        exp_edrop = enq_valid && !room;
        if (enq_valid && room) mq[enq_qid].push_back(int'(enq_desc));
        if (enq_valid && !room && eok) mdrop[enq_qid] = (mdrop[enq_qid] + 1) % (1 << DROP_W);
    endtask

    task automatic compare();
        bit dep_ok = 1'b1, drp_ok = 1'b1, req_ok = 1'b1;
        int bad_q = 0;
        for (int q = 0; q < NQ; q++) begin
            if (int'(depth[q*CNT_W +: CNT_W]) != mq[q].size()) begin dep_ok = 0; bad_q = q; end
            if (int'(drops[q*DROP_W +: DROP_W]) != mdrop[q]) drp_ok = 0;
            if (req[q] != (mq[q].size() > 0 && !bp[q])) req_ok = 0;
        end
        chk(dep_ok, "R2 R6 depth", int'(depth[bad_q*CNT_W +: CNT_W]), mq[bad_q].size());
        chk(drp_ok, "R5 drop counter", 0, 1);
        chk(req_ok, "R4 request", int'(req), 0);
        chk(deq_valid == exp_dv, "R3 deq_valid", int'(deq_valid), int'(exp_dv));
        if (exp_dv && deq_valid)
            chk(int'(deq_desc) == exp_desc, "R1 R3 descriptor order", int'(deq_desc), exp_desc);
        chk(gnt_err == exp_err, "R8 grant error", int'(gnt_err), int'(exp_err));
        chk(enq_drop == exp_edrop, "R5 R7 enqueue refusal", int'(enq_drop), int'(exp_edrop));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic cyc(input bit ev, input int eq, input bit gv, input int gq);
        enq_valid = ev;
        enq_qid   = QID_W'(eq);
        enq_desc  = DESC_W'(tag);
        tag++;
        gnt_valid = gv;
        gnt_qid   = QID_W'(gq);
        step();
    endtask

    task automatic set_all_limits(input int v);
        for (int q = 0; q < NQ; q++) limit[q*CNT_W +: CNT_W] = CNT_W'(v);
    endtask

    task automatic drain_all();
        for (int q = 0; q < NQ; q++) begin
            while (mq[q].size() > 0) cyc(0, 0, 1, q);
        end
        cyc(0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int q = 0; q < NQ; q++) mdrop[q] = 0;
        exp_dv = 0; exp_err = 0; exp_edrop = 0; exp_desc = 0;
        set_all_limits(DEPTH);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(depth == '0 && drops == '0, "R10 counts at reset", int'(depth[CNT_W-1:0]), 0);
        chk(req == '0 && !deq_valid && !gnt_err && !enq_drop, "R10 flags at reset", int'(req), 0);
        rst_n = 1'b1;
        compare();

        // R1 ordering across queues, R3 dequeue
        for (int i = 0; i < 3; i++) cyc(1, 3, 0, 0);
        cyc(1, NS, 0, 0);
        cyc(1, NS, 0, 0);
        cyc(1, NS + 1, 0, 0);
        chk(int'(depth[(NS+1)*CNT_W +: CNT_W]) == 1, "R1 raw queue count", int'(depth[(NS+1)*CNT_W +: CNT_W]), 1);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 3);
        cyc(0, 0, 1, NS);

        // R6 backpressure isolation
        bp[5] = 1'b1;
        for (int i = 0; i < 4; i++) cyc(1, 5, 0, 0);
        cyc(1, 6, 0, 0);
        cyc(1, 6, 1, 5);      // R8 grant to backpressured queue
        cyc(0, 0, 1, 6);      // R6 other queue still served
        chk(int'(depth[5*CNT_W +: CNT_W]) == 4, "R6 held queue keeps contents", int'(depth[5*CNT_W +: CNT_W]), 4);
        bp[5] = 1'b0;
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 5);

        // R8 empty and out-of-range grants; R5 out-of-range enqueue
        cyc(0, 0, 1, 0);
        cyc(0, 0, 1, 20);
        cyc(1, 21, 0, 0);

        // R5 limit
        limit[2*CNT_W +: CNT_W] = CNT_W'(3);
        for (int i = 0; i < 5; i++) cyc(1, 2, 0, 0);
        chk(int'(drops[2*DROP_W +: DROP_W]) == 2, "R5 drops at limit", int'(drops[2*DROP_W +: DROP_W]), 2);
        limit[7*CNT_W +: CNT_W] = '0;
        cyc(1, 7, 0, 0);

        // R9 simultaneous enqueue and grant on one queue
        cyc(1, 9, 0, 0);
        cyc(1, 9, 1, 9);
        chk(int'(depth[9*CNT_W +: CNT_W]) == 1, "R9 depth one kept", int'(depth[9*CNT_W +: CNT_W]), 1);
        cyc(1, 9, 0, 0);
        cyc(1, 9, 1, 9);
        cyc(0, 0, 1, 9);
        cyc(0, 0, 1, 9);

        // R7 shared storage exhaustion
        begin
            int k = 0;
            while (total_stored() < DEPTH) begin
                cyc(1, 10 + (k % 6), 0, 0);
                k++;
            end
        end
        cyc(1, 11, 0, 0);
        cyc(1, 12, 1, 10);    // refused although an entry frees now
        cyc(1, 12, 0, 0);     // accepted next cycle
        chk(total_stored() == DEPTH, "R7 store full again", total_stored(), DEPTH);
        drain_all();

        // mixed random traffic
        for (int c = 0; c < 4000; c++) begin
            if (c % 16 == 0) begin
                for (int q = 0; q < NQ; q++) bp[q] = ($urandom % 4 == 0);
            end
            if (c % 250 == 0) begin
                for (int q = 0; q < NQ; q++)
                    limit[q*CNT_W +: CNT_W] = CNT_W'(($urandom % 3 == 0) ? ($urandom % 9) : DEPTH);
            end
            cyc(($urandom % 4) != 0, $urandom % 20, ($urandom % 3) != 0,
                ($urandom % 8 == 0) ? ($urandom % 32) : ($urandom % NQ));
        end
        bp = '0;
        set_all_limits(DEPTH);
        drain_all();
        chk(depth == '0, "R2 drained", 0, 0);
        finish_run();
    end

endmodule